// File: doc/BRIEF.md
# Reset-Window Lane Stack Configuration Controller

This block keeps the lane layout of four port stacks in a multi-port switch. Each stack owns eight lanes and up to four ports. On the first clock edge after the active-low reset is released, every stack's configuration code is taken from its strap pins. The two narrow stacks have two strap pins each, and the two wide stacks have five. The stored code is turned into a per-port lane-width code and a port-present mask. Both are registered one cycle after the code changes.

While the fundamental reset sequence is still in progress, a boot-time EEPROM loader or an SMBus slave may write a new code for a stack. The write only takes effect if the source matches the phase that is currently open, every port of that stack is in the disabled mode, and the code is one of the 26 defined layouts. A write from PCI Express configuration space never takes effect. Once the sequence-done flag arrives, the codes are frozen until the next reset.

Each port's active, link-up and hot-plug indications are passed through only when the port is present and not disabled. Otherwise they are held low.

The sequencer has three states:
- SAMPLE: the reset state. It moves to OPEN on the first clock edge after reset, capturing the straps on that edge.
- OPEN: writes are possible here. It moves to LOCKED when `seq_done` is high at an edge.
- LOCKED: final until the next reset.

Top module: `scfg_ctrl`

## Requirements
- R1: While `rst_n` is low, every code, width and error bit reads 0, `port_present` is 0 and `locked` is 0. Reset also clears the error flags.
- R2: On the first edge after reset, stacks 0 and 1 load their two strap bits into code bits [1:0] and bits [4:2] load as 0.
- R3: On that same edge, stacks 2 and 3 load all five strap bits. A wide strap value of 26 or more loads code 0 and sets that stack's error flag.
- R4: Width codes are 0 for unused, 1 for x1, 2 for x2, 3 for x4 and 4 for x8. They appear one edge after a code change. The code is read as group = bits [4:3] and base = bits [1:0], and widths fill ports from port 0. The layouts for group 0 are x8; x4,x4; x4,x2,x2; x2,x2,x2,x2. Group 1: x4,x2,x1,x1; x2,x2,x2,x1; x4,x1,x1,x1; x2,x1,x1,x1. Group 2: x2,x4,x2; x2,x4,x1,x1; x1,x4,x1,x1; x4,x1,x2. Group 3: x1,x1,x1,x1; x2,x1,x2.
- R5: Code bit 2 reverses the order of the widths over the ports in use. For example, 0x2 gives x4,x2,x2 and 0x6 gives x2,x2,x4.
- R6: A write (`wr_src` 0 = EEPROM, 1 = SMBus) is accepted only in the OPEN state. An EEPROM write also needs `eeprom_phase`, and an SMBus write also needs `quasi_reset`. A write outside its window changes neither the code nor the error flag.
- R7: A write with `wr_src` = 2 (PCI Express) never changes a code or an error flag.
- R8: `seq_done` in OPEN moves the block to LOCKED and raises `locked`. After that, no write changes any code.
- R9: An in-window write while any port of the target stack has a mode other than 2'b00 (disabled) leaves the code unchanged and sets that stack's error flag.
- R10: An in-window write of a code of 26 or more leaves the code unchanged and sets the error flag.
- R11: Error flags are sticky until reset.
- R12: A port that is disabled or not present drives `port_active`, `port_link_up` and `hp_event` low, whatever its raw inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low fundamental reset |
| strap_narrow | input | 4 | Two strap bits for each of stacks 0 and 1 |
| strap_wide | input | 10 | Five strap bits for each of stacks 2 and 3 |
| seq_done | input | 1 | Reset sequence has finished |
| eeprom_phase | input | 1 | EEPROM load step is in progress |
| quasi_reset | input | 1 | Ports are in quasi-reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_src | input | 2 | Write source: 0 EEPROM, 1 SMBus, 2 PCI Express |
| wr_stack | input | 2 | Target stack |
| wr_code | input | 5 | New configuration code |
| port_mode | input | 32 | Two-bit operating mode per port; 0 means disabled |
| active_raw | input | 16 | Raw per-port active indication |
| link_raw | input | 16 | Raw per-port link-up indication |
| hp_raw | input | 16 | Raw per-port hot-plug event |
| cfg_code | output | 20 | Stored code, five bits per stack |
| port_width | output | 48 | Three-bit width code per port |
| port_present | output | 16 | Port is used by its stack's layout |
| port_active | output | 16 | Gated active indication |
| port_link_up | output | 16 | Gated link-up indication |
| hp_event | output | 16 | Gated hot-plug event |
| cfg_err | output | 4 | Sticky per-stack reject flag |
| locked | output | 1 | Reconfiguration window closed |

## Verification
The assertions assume that no PCI Express-tagged write is presented on the capture edge that directly follows reset release, because the strap load legitimately changes the codes on that edge. They also assume that `seq_done` is not raised in the same cycle as a write. The stimulus follows both rules: every write is issued at least two edges after reset and apart from the `seq_done` pulse. Mode changes are applied at falling edges, so the pass-through gating is always checked against settled inputs.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

    localparam int CODE_W          = 5;
    localparam int PORTS_PER_STACK = 4;
    localparam int WIDTH_W         = 3;
    localparam int MODE_W          = 2;

    typedef enum logic [1:0] {
        SRC_EEPROM = 2'd0,
        SRC_SMBUS  = 2'd1,
        SRC_PCIE   = 2'd2,
        SRC_RSVD   = 2'd3
    } wr_src_e;

    typedef enum logic [2:0] {
        LW_NONE = 3'd0,
        LW_X1   = 3'd1,
        LW_X2   = 3'd2,
        LW_X4   = 3'd3,
        LW_X8   = 3'd4
    } lane_w_e;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_OPEN   = 2'd1,
        ST_LOCKED = 2'd2
    } seq_state_e;

    localparam logic [MODE_W-1:0] MODE_DISABLED = '0;

    typedef logic [PORTS_PER_STACK*WIDTH_W-1:0] layout_t;

    // Group (bits 4:3) and base (bits 1:0) pick a layout; bit 2 reverses it.
    function automatic layout_t layout_of(input logic [CODE_W-1:0] code);
        lane_w_e base [PORTS_PER_STACK];
        lane_w_e outw [PORTS_PER_STACK];
        int      n;
        int      idx;
        layout_t r;
        for (int k = 0; k < PORTS_PER_STACK; k++) begin
            base[k] = LW_NONE;
            outw[k] = LW_NONE;
        end
        n = 0;
        case ({code[4:3], code[1:0]})
            4'b00_00: begin base[0] = LW_X8; n = 1; end
            4'b00_01: begin base[0] = LW_X4; base[1] = LW_X4; n = 2; end
            4'b00_10: begin base[0] = LW_X4; base[1] = LW_X2; base[2] = LW_X2; n = 3; end
            4'b00_11: begin base[0] = LW_X2; base[1] = LW_X2; base[2] = LW_X2; base[3] = LW_X2; n = 4; end
            4'b01_00: begin base[0] = LW_X4; base[1] = LW_X2; base[2] = LW_X1; base[3] = LW_X1; n = 4; end
            4'b01_01: begin base[0] = LW_X2; base[1] = LW_X2; base[2] = LW_X2; base[3] = LW_X1; n = 4; end
            4'b01_10: begin base[0] = LW_X4; base[1] = LW_X1; base[2] = LW_X1; base[3] = LW_X1; n = 4; end
            4'b01_11: begin base[0] = LW_X2; base[1] = LW_X1; base[2] = LW_X1; base[3] = LW_X1; n = 4; end
            4'b10_00: begin base[0] = LW_X2; base[1] = LW_X4; base[2] = LW_X2; n = 3; end
            4'b10_01: begin base[0] = LW_X2; base[1] = LW_X4; base[2] = LW_X1; base[3] = LW_X1; n = 4; end
            4'b10_10: begin base[0] = LW_X1; base[1] = LW_X4; base[2] = LW_X1; base[3] = LW_X1; n = 4; end
            4'b10_11: begin base[0] = LW_X4; base[1] = LW_X1; base[2] = LW_X2; n = 3; end
            4'b11_00: begin base[0] = LW_X1; base[1] = LW_X1; base[2] = LW_X1; base[3] = LW_X1; n = 4; end
            4'b11_01: begin base[0] = LW_X2; base[1] = LW_X1; base[2] = LW_X2; n = 3; end
            default:  n = 0;
        endcase
        for (int k = 0; k < PORTS_PER_STACK; k++) begin
            if (k < n) begin
                idx = code[2] ? (n - 1 - k) : k;
                outw[k] = base[idx[1:0]];
            end
        end
        r = '0;
        for (int k = 0; k < PORTS_PER_STACK; k++) begin
            r[k*WIDTH_W +: WIDTH_W] = outw[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/scfg_seq.sv
module scfg_seq
    import scfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seq_done,
    output logic capture,
    output logic open_win,
    output logic locked
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = ST_OPEN;
            ST_OPEN:   if (seq_done) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_SAMPLE;
        endcase
    end

    always_comb begin
        capture  = 1'b0;
        open_win = 1'b0;
        locked   = 1'b0;
        unique case (state_q)
            ST_SAMPLE: capture  = 1'b1;
            ST_OPEN:   open_win = 1'b1;
            ST_LOCKED: locked   = 1'b1;
            default:   capture  = 1'b0;
        endcase
    end

endmodule

// File: rtl/scfg_stack_reg.sv
module scfg_stack_reg
    import scfg_pkg::*;
#(
    parameter int STRAP_W   = 2,
    parameter int NUM_CODES = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [STRAP_W-1:0] strap,
    input  logic               wr_hit,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic               ports_off,
    output logic [CODE_W-1:0]  code_q,
    output logic               err_q
);

    localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(NUM_CODES);

    logic [CODE_W-1:0] strap_code;
    logic              strap_ok;
    logic              wr_ok;

    assign strap_code = CODE_W'(strap);
    assign strap_ok   = {1'b0, strap_code} < LIMIT;
    assign wr_ok      = ports_off && ({1'b0, wr_code} < LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            err_q  <= 1'b0;
        end else if (capture) begin
            code_q <= strap_ok ? strap_code : '0;
            if (!strap_ok) err_q <= 1'b1;
        end else if (wr_hit) begin
            if (wr_ok) code_q <= wr_code;
            else       err_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/scfg_decode.sv
module scfg_decode
    import scfg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CODE_W-1:0]           code,
    output logic [PORTS_PER_STACK*WIDTH_W-1:0] width_q,
    output logic [PORTS_PER_STACK-1:0]  present_q
);

    layout_t lay;
    logic [PORTS_PER_STACK-1:0] pres;

    always_comb begin
        lay = layout_of(code);
        for (int k = 0; k < PORTS_PER_STACK; k++) begin
            pres[k] = |lay[k*WIDTH_W +: WIDTH_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q   <= '0;
            present_q <= '0;
        end else begin
            width_q   <= lay;
            present_q <= pres;
        end
    end

endmodule

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
    import scfg_pkg::*;
#(
    parameter int NUM_STACKS    = 4,
    parameter int NARROW_STACKS = 2,
    parameter int NARROW_W      = 2,
    parameter int NUM_CODES     = 26,
    localparam int NUM_PORTS    = NUM_STACKS * PORTS_PER_STACK,
    localparam int SEL_W        = $clog2(NUM_STACKS),
    localparam int WIDE_STACKS  = NUM_STACKS - NARROW_STACKS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NARROW_STACKS*NARROW_W-1:0] strap_narrow,
    input  logic [WIDE_STACKS*CODE_W-1:0] strap_wide,
    input  logic                          seq_done,
    input  logic                          eeprom_phase,
    input  logic                          quasi_reset,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_src,
    input  logic [SEL_W-1:0]              wr_stack,
    input  logic [CODE_W-1:0]             wr_code,
    input  logic [NUM_PORTS*MODE_W-1:0]   port_mode,
    input  logic [NUM_PORTS-1:0]          active_raw,
    input  logic [NUM_PORTS-1:0]          link_raw,
    input  logic [NUM_PORTS-1:0]          hp_raw,
    output logic [NUM_STACKS*CODE_W-1:0]  cfg_code,
    output logic [NUM_PORTS*WIDTH_W-1:0]  port_width,
    output logic [NUM_PORTS-1:0]          port_present,
    output logic [NUM_PORTS-1:0]          port_active,
    output logic [NUM_PORTS-1:0]          port_link_up,
    output logic [NUM_PORTS-1:0]          hp_event,
    output logic [NUM_STACKS-1:0]         cfg_err,
    output logic                          locked
);

    logic capture;
    logic open_win;
    logic src_ok;
    logic wr_live;
    logic [NUM_PORTS-1:0] port_on;

    scfg_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_done (seq_done),
        .capture  (capture),
        .open_win (open_win),
        .locked   (locked)
    );

    always_comb begin
        unique case (wr_src_e'(wr_src))
            SRC_EEPROM: src_ok = eeprom_phase;
            SRC_SMBUS:  src_ok = quasi_reset;
            SRC_PCIE:   src_ok = 1'b0;
            default:    src_ok = 1'b0;
        endcase
    end

    assign wr_live = wr_en && open_win && src_ok;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_on[p]      = port_present[p] &&
                                 (port_mode[p*MODE_W +: MODE_W] != MODE_DISABLED);
        assign port_active[p]  = active_raw[p] && port_on[p];
        assign port_link_up[p] = link_raw[p]   && port_on[p];
        assign hp_event[p]     = hp_raw[p]     && port_on[p];
    end

    for (genvar s = 0; s < NUM_STACKS; s++) begin : g_stack
        logic ports_off;
        logic wr_hit;

        always_comb begin
            ports_off = 1'b1;
            for (int k = 0; k < PORTS_PER_STACK; k++) begin
                if (port_mode[(s*PORTS_PER_STACK+k)*MODE_W +: MODE_W] != MODE_DISABLED)
                    ports_off = 1'b0;
            end
        end

        assign wr_hit = wr_live && (wr_stack == SEL_W'(s));

        if (s < NARROW_STACKS) begin : g_narrow
            scfg_stack_reg #(.STRAP_W(NARROW_W), .NUM_CODES(NUM_CODES)) u_reg (
                .clk       (clk),
                .rst_n     (rst_n),
                .capture   (capture),
                .strap     (strap_narrow[s*NARROW_W +: NARROW_W]),
                .wr_hit    (wr_hit),
                .wr_code   (wr_code),
                .ports_off (ports_off),
                .code_q    (cfg_code[s*CODE_W +: CODE_W]),
                .err_q     (cfg_err[s])
            );
        end else begin : g_wide
            scfg_stack_reg #(.STRAP_W(CODE_W), .NUM_CODES(NUM_CODES)) u_reg (
                .clk       (clk),
                .rst_n     (rst_n),
                .capture   (capture),
                .strap     (strap_wide[(s-NARROW_STACKS)*CODE_W +: CODE_W]),
                .wr_hit    (wr_hit),
                .wr_code   (wr_code),
                .ports_off (ports_off),
                .code_q    (cfg_code[s*CODE_W +: CODE_W]),
                .err_q     (cfg_err[s])
            );
        end

        scfg_decode u_dec (
            .clk       (clk),
            .rst_n     (rst_n),
            .code      (cfg_code[s*CODE_W +: CODE_W]),
            .width_q   (port_width[s*PORTS_PER_STACK*WIDTH_W +: PORTS_PER_STACK*WIDTH_W]),
            .present_q (port_present[s*PORTS_PER_STACK +: PORTS_PER_STACK])
        );
    end

endmodule

// File: rtl/scfg_ctrl_chk.sv
module scfg_ctrl_chk
    import scfg_pkg::*;
#(
    parameter int NUM_STACKS = 4,
    parameter int NUM_CODES  = 26,
    localparam int NUM_PORTS = NUM_STACKS * PORTS_PER_STACK
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         locked,
    input logic                         wr_en,
    input logic [1:0]                   wr_src,
    input logic [NUM_STACKS*CODE_W-1:0] cfg_code,
    input logic [NUM_STACKS-1:0]        cfg_err,
    input logic [NUM_PORTS*MODE_W-1:0]  port_mode,
    input logic [NUM_PORTS-1:0]         port_active,
    input logic [NUM_PORTS-1:0]         port_link_up,
    input logic [NUM_PORTS-1:0]         hp_event
);

    localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(NUM_CODES);

    p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(cfg_code)));

    p_pcie_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_src == SRC_PCIE) |=> ($stable(cfg_code) && $stable(cfg_err)));

    for (genvar s = 0; s < NUM_STACKS; s++) begin : g_s
        p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_err[s] |=> cfg_err[s]);
        p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ({1'b0, cfg_code[s*CODE_W +: CODE_W]} < LIMIT));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (port_mode[p*MODE_W +: MODE_W] == MODE_DISABLED) |->
                !(port_active[p] || port_link_up[p] || hp_event[p]));
    end

endmodule

bind scfg_ctrl scfg_ctrl_chk #(.NUM_STACKS(NUM_STACKS), .NUM_CODES(NUM_CODES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .locked       (locked),
    .wr_en        (wr_en),
    .wr_src       (wr_src),
    .cfg_code     (cfg_code),
    .cfg_err      (cfg_err),
    .port_mode    (port_mode),
    .port_active  (port_active),
    .port_link_up (port_link_up),
    .hp_event     (hp_event)
);

// File: tb/sim_scfg_ctrl.sv
module sim_scfg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_narrow;
    logic [9:0]  strap_wide;
    logic        seq_done = 1'b0;
    logic        eeprom_phase = 1'b0;
    logic        quasi_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_src = 2'd0;
    logic [1:0]  wr_stack = 2'd0;
    logic [4:0]  wr_code = 5'd0;
    logic [31:0] port_mode;
    logic [15:0] active_raw = '1;
    logic [15:0] link_raw = '1;
    logic [15:0] hp_raw = '1;
    logic [19:0] cfg_code;
    logic [47:0] port_width;
    logic [15:0] port_present;
    logic [15:0] port_active;
    logic [15:0] port_link_up;
    logic [15:0] hp_event;
    logic [3:0]  cfg_err;
    logic        locked;

    always #4 clk = ~clk;

    scfg_ctrl u0 (.*);

    typedef struct {
        int    kind;
        int    idx;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // kinds: 0 code, 1 width, 2 err, 3 active, 4 link, 5 hotplug, 6 locked, 7 present
    function automatic int actual_of(int kind, int idx);
        case (kind)
            0: return int'(cfg_code[idx*5 +: 5]);
            1: return int'(port_width[idx*3 +: 3]);
            2: return int'(cfg_err[idx]);
            3: return int'(port_active[idx]);
            4: return int'(port_link_up[idx]);
            5: return int'(hp_event[idx]);
            6: return int'(locked);
            default: return int'(port_present[idx]);
        endcase
    endfunction

    task automatic expect_v(int kind, int idx, int exp, string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic expect_widths(int stack, int w0, int w1, int w2, int w3, string req);
        expect_v(1, stack*4+0, w0, req);
        expect_v(1, stack*4+1, w1, req);
        expect_v(1, stack*4+2, w2, req);
        expect_v(1, stack*4+3, w3, req);
    endtask

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            act = actual_of(it.kind, it.idx);
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s kind %0d idx %0d actual %0d expected %0d",
                         it.req, it.kind, it.idx, act, it.exp);
            end
        end
    end

    task automatic do_write(int src, int stack, int code);
        @(negedge clk);
        wr_en = 1'b1; wr_src = 2'(src); wr_stack = 2'(stack); wr_code = 5'(code);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        strap_narrow = {2'b11, 2'b10};
        strap_wide   = {5'd25, 5'b00110};
        port_mode    = {16{2'b01}};
        repeat (3) @(posedge clk);
        #1;
        for (int s = 0; s < 4; s++) begin
            expect_v(0, s, 0, "R1"); expect_v(2, s, 0, "R1");
        end
        expect_v(7, 0, 0, "R1"); expect_v(1, 0, 0, "R1"); expect_v(6, 0, 0, "R1");

        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        expect_v(0, 0, 2, "R2"); expect_v(0, 1, 3, "R2");
        expect_v(0, 2, 6, "R3"); expect_v(0, 3, 25, "R3");
        expect_v(2, 3, 0, "R3");
        expect_widths(0, 3, 2, 2, 0, "R4");
        expect_widths(1, 2, 2, 2, 2, "R4");
        expect_widths(2, 2, 2, 3, 0, "R5");
        expect_widths(3, 2, 1, 2, 0, "R4");
        expect_v(7, 15, 0, "R4");
        expect_v(3, 12, 1, "R12"); expect_v(3, 15, 0, "R12");

        eeprom_phase = 1'b1;
        do_write(0, 0, 1);
        expect_v(0, 0, 2, "R9"); expect_v(2, 0, 1, "R9");

        @(negedge clk) port_mode[7:0] = '0;
        do_write(0, 0, 1);
        expect_v(0, 0, 1, "R6");
        expect_widths(0, 3, 3, 0, 0, "R4");
        for (int p = 0; p < 4; p++) begin
            expect_v(3, p, 0, "R12"); expect_v(4, p, 0, "R12"); expect_v(5, p, 0, "R12");
        end
        expect_v(4, 13, 1, "R12");

        @(negedge clk) begin eeprom_phase = 1'b0; quasi_reset = 1'b0; end
        do_write(1, 0, 0);
        expect_v(0, 0, 1, "R6"); expect_v(2, 1, 0, "R6");
        do_write(0, 0, 0);
        expect_v(0, 0, 1, "R6");

        @(negedge clk) quasi_reset = 1'b1;
        do_write(1, 0, 0);
        expect_v(0, 0, 0, "R6");
        expect_widths(0, 4, 0, 0, 0, "R4");

        @(negedge clk) begin port_mode[15:8] = '0; eeprom_phase = 1'b1; end
        do_write(2, 1, 0);
        expect_v(0, 1, 3, "R7"); expect_v(2, 1, 0, "R7");

        do_write(0, 1, 26);
        expect_v(0, 1, 3, "R10"); expect_v(2, 1, 1, "R10");

        do_write(0, 1, 12);
        expect_v(0, 1, 12, "R5");
        expect_widths(1, 1, 1, 2, 3, "R5");
        expect_v(2, 0, 1, "R11");

        do_write(0, 1, 9);
        expect_widths(1, 2, 2, 2, 1, "R4");

        @(negedge clk) seq_done = 1'b1;
        @(negedge clk) seq_done = 1'b0;
        @(posedge clk); #1;
        expect_v(6, 0, 1, "R8");

        do_write(0, 1, 0);
        expect_v(0, 1, 9, "R8");
        do_write(1, 0, 2);
        expect_v(0, 0, 0, "R8");

        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        expect_v(2, 0, 0, "R11"); expect_v(2, 1, 0, "R11"); expect_v(6, 0, 0, "R1");

        @(negedge clk); @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule